// File: doc/BRIEF.md
# Dual-format serial audio transmitter

This block takes a stereo pair of 24-bit two's-complement samples and shifts them out MSB first on one serial data line. It follows a bit clock and a frame clock that arrive as inputs. Both clocks are sampled in the system clock domain, so they may come from a local divider or from outside the chip. The block does not generate either clock.

A single format input selects the framing. In left-justified framing the frame clock is high for the left channel, and the MSB goes out in the first bit period after the frame clock edge. In I2S framing the frame clock is low for the left channel, and the MSB is delayed by one bit period.

When a half frame lasts only 16 bit periods (bit clock at 32 times the sample rate), the word is cut to its upper 16 bits. In I2S framing at that rate, the 16th bit spills into the first bit period of the following half frame. A power-down input forces the line low and restarts the frame tracking.

Top module: `dual_fmt_audio_tx`

## Requirements
- R1: After reset `sdata` is 0, and it stays 0 across bit clock falls until the first frame clock change is seen at a bit clock fall.
- R2: `sdata` changes only on the system clock edge where a bit clock fall is detected (bit clock 1 on the previous edge, 0 now). It holds steady through the bit clock high phase.
- R3: With `fmt_i2s`=0 (left-justified), the left word goes out while `lrck` is 1. The frame clock change and word bit 23 share the same bit period (slot 0), and bits 22..0 follow in slots 1..23.
- R4: With `fmt_i2s`=1 (I2S), the left word goes out while `lrck` is 0. Slot 0 carries 0 (or the spill bit of R8), and bits 23..0 occupy slots 1..24.
- R5: In a 32-slot half frame, every slot after the last data bit carries 0 until the next frame clock change.
- R6: Both input words are captured at the frame clock change that opens the left half frame. Later changes on `left_in` or `right_in` have no effect until the next such change.
- R7: While `pwr_dn`=1, `sdata` is 0 from the next system clock edge onward, and the captured words are cleared. After release, output resumes at the next frame clock change.
- R8: A half frame is treated as 16-bit when the half frame that just ended had exactly 16 slots. In left-justified framing only bits 23..8 appear (slots 0..15). In I2S framing bits 23..9 fill slots 1..15 and bit 8 appears in slot 0 of the next half frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state is registered on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Power-down, active high |
| fmt_i2s | input | 1 | Framing select: 0 left-justified, 1 I2S |
| bclk | input | 1 | Bit clock, sampled by `clk` |
| lrck | input | 1 | Frame clock, sampled by `clk` |
| left_in | input | 24 | Left sample, two's complement |
| right_in | input | 24 | Right sample, two's complement |
| sdata | output | 1 | Serial data output |

## Verification
A slot counter that loses track of the frame clock change shifts every bit of the half frame, so the whole word comes out misaligned within that same half frame. A fault in word capture shows as right-channel data following inputs that changed after the left half began. A wrong 16-bit flag only shows in I2S at the short rate, and it first appears as a wrong slot 0 in the half frame after the first short one. Power-down faults show as a 1 on the line one system clock after `pwr_dn` rises.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
  typedef enum logic {
    FMT_LEFT_JUST = 1'b0,
    FMT_I2S       = 1'b1
  } fmt_e;
endpackage

// File: rtl/aud_tx_edge.sv
module aud_tx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  output logic fall_ev
);
  logic bclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_d <= 1'b0;
    else        bclk_d <= bclk;
  end

  assign fall_ev = bclk_d & ~bclk;
endmodule

// File: rtl/aud_tx_slot.sv
module aud_tx_slot #(
  parameter int unsigned CNT_W       = 6,
  parameter int unsigned SHORT_SLOTS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_dn,
  input  logic             fall_ev,
  input  logic             lrck,
  output logic             frame_edge,
  output logic [CNT_W-1:0] slot_q,
  output logic [CNT_W-1:0] slot_nxt,
  output logic             short_q,
  output logic             short_nxt
);
  localparam logic [CNT_W-1:0] SLOT_MAX  = '1;
  localparam logic [CNT_W-1:0] SHORT_END = CNT_W'(SHORT_SLOTS - 1);

  logic lr_prev;

  assign frame_edge = fall_ev & ~pwr_dn & (lrck != lr_prev);

  always_comb begin
    if (frame_edge)            slot_nxt = '0;
    else if (slot_q == SLOT_MAX) slot_nxt = SLOT_MAX;
    else                       slot_nxt = slot_q + 1'b1;
    short_nxt = frame_edge ? (slot_q == SHORT_END) : short_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_prev <= 1'b0;
      slot_q  <= SLOT_MAX;
      short_q <= 1'b0;
    end else if (pwr_dn) begin
      lr_prev <= lrck;
      slot_q  <= SLOT_MAX;
      short_q <= 1'b0;
    end else if (fall_ev) begin
      lr_prev <= lrck;
      slot_q  <= slot_nxt;
      short_q <= short_nxt;
    end
  end
endmodule

// File: rtl/aud_tx_hold.sv
module aud_tx_hold #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwr_dn,
  input  logic         load,
  input  logic [W-1:0] left_in,
  input  logic [W-1:0] right_in,
  output logic [W-1:0] l_hold,
  output logic [W-1:0] r_hold
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_hold <= '0;
      r_hold <= '0;
    end else if (pwr_dn) begin
      l_hold <= '0;
      r_hold <= '0;
    end else if (load) begin
      l_hold <= left_in;
      r_hold <= right_in;
    end
  end
endmodule

// File: rtl/dual_fmt_audio_tx.sv
module dual_fmt_audio_tx #(
  parameter int unsigned SAMPLE_W  = 24,
  parameter int unsigned SHORT_W   = 16,
  parameter int unsigned MAX_SLOTS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pwr_dn,
  input  logic                fmt_i2s,
  input  logic                bclk,
  input  logic                lrck,
  input  logic [SAMPLE_W-1:0] left_in,
  input  logic [SAMPLE_W-1:0] right_in,
  output logic                sdata
);
  import aud_tx_pkg::*;

  localparam int unsigned CNT_W = $clog2(MAX_SLOTS) + 1;
  localparam int unsigned IDX_W = $clog2(SAMPLE_W);

  // Bit carried by one slot: left-justified puts bit (W-1-slot) in slot,
  // I2S shifts by one and reuses slot 0 for the spill bit of a short word.
  function automatic logic slot_bit(
    input logic [SAMPLE_W-1:0] cur,
    input logic [SAMPLE_W-1:0] prev,
    input logic [CNT_W-1:0]    slot,
    input fmt_e                fmt,
    input logic                short16
  );
    int s;
    logic r;
    s = int'(slot);
    r = 1'b0;
    if (fmt == FMT_LEFT_JUST) begin
      if (s < int'(SAMPLE_W)) r = cur[IDX_W'(int'(SAMPLE_W) - 1 - s)];
    end else if (s == 0) begin
      r = short16 ? prev[SAMPLE_W-SHORT_W] : 1'b0;
    end else if (s <= int'(SAMPLE_W)) begin
      r = cur[IDX_W'(int'(SAMPLE_W) - s)];
    end
    return r;
  endfunction

  // Internal events, named for the checker
  logic                fall_ev;
  logic                frame_edge;
  logic                left_start;
  logic                left_nxt;
  logic [CNT_W-1:0]    slot_q, slot_nxt;
  logic                short_q, short_nxt;
  logic [SAMPLE_W-1:0] l_hold, r_hold;
  logic [SAMPLE_W-1:0] word_cur, word_prev;
  fmt_e                fmt;

  assign fmt = fmt_e'(fmt_i2s);

  aud_tx_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .bclk    (bclk),
    .fall_ev (fall_ev)
  );

  aud_tx_slot #(.CNT_W(CNT_W), .SHORT_SLOTS(SHORT_W)) u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_dn     (pwr_dn),
    .fall_ev    (fall_ev),
    .lrck       (lrck),
    .frame_edge (frame_edge),
    .slot_q     (slot_q),
    .slot_nxt   (slot_nxt),
    .short_q    (short_q),
    .short_nxt  (short_nxt)
  );

  assign left_nxt   = (fmt == FMT_I2S) ? ~lrck : lrck;
  assign left_start = frame_edge & left_nxt;

  aud_tx_hold #(.W(SAMPLE_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_dn   (pwr_dn),
    .load     (left_start),
    .left_in  (left_in),
    .right_in (right_in),
    .l_hold   (l_hold),
    .r_hold   (r_hold)
  );

  always_comb begin
    if (left_nxt) begin
      word_cur  = left_start ? left_in : l_hold;
      word_prev = r_hold;
    end else begin
      word_cur  = r_hold;
      word_prev = l_hold;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sdata <= 1'b0;
    else if (pwr_dn)  sdata <= 1'b0;
    else if (fall_ev) sdata <= slot_bit(word_cur, word_prev, slot_nxt, fmt, short_nxt);
  end
endmodule

// File: rtl/aud_tx_chk.sv
module aud_tx_chk #(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned CNT_W    = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                pwr_dn,
  input logic                sdata,
  input logic                fall_ev,
  input logic                frame_edge,
  input logic                left_start,
  input logic [CNT_W-1:0]    slot_q,
  input logic                short_q,
  input logic [SAMPLE_W-1:0] left_in,
  input logic [SAMPLE_W-1:0] l_hold
);
  assert_pd_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pwr_dn) |-> !sdata);

  assert_change_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(fall_ev) && !$past(pwr_dn)) |-> $stable(sdata));

  assert_slot_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_edge |=> (slot_q == '0));

  assert_tail_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fall_ev) && !$past(pwr_dn) && (int'(slot_q) > int'(SAMPLE_W))) |-> !sdata);

  assert_word_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    left_start |=> (l_hold == $past(left_in)));

  assert_short_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(frame_edge) && !$past(pwr_dn)) |-> $stable(short_q));
endmodule

bind dual_fmt_audio_tx aud_tx_chk #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr_dn     (pwr_dn),
  .sdata      (sdata),
  .fall_ev    (fall_ev),
  .frame_edge (frame_edge),
  .left_start (left_start),
  .slot_q     (slot_q),
  .short_q    (short_q),
  .left_in    (left_in),
  .l_hold     (l_hold)
);

// File: tb/dual_fmt_audio_tx_tb_top.sv
module dual_fmt_audio_tx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, pwr_dn, fmt_i2s, bclk, lrck;
  logic [23:0] left_in, right_in;
  logic        sdata;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [23:0] prev_w;
  int          prev_len;

  always #10 clk = ~clk;

  dual_fmt_audio_tx dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .fmt_i2s(fmt_i2s),
    .bclk(bclk), .lrck(lrck), .left_in(left_in), .right_in(right_in),
    .sdata(sdata)
  );

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // One bit period: fall (with frame clock update), sample at rise, recheck late in high phase
  task automatic drive_slot(input logic lr, output logic b, output logic steady);
    @(negedge clk); bclk = 1'b0; lrck = lr;
    @(negedge clk);
    @(negedge clk); b = sdata; bclk = 1'b1;
    @(negedge clk); steady = (sdata == b);
  endtask

  task automatic run_half(input logic lr, input logic [23:0] w, input int n, input bit i2s, input string tag);
    logic [31:0] cap, exp;
    logic b, st, all_st;
    cap = '0; exp = '0; all_st = 1'b1;
    for (int s = 0; s < n; s++) begin
      drive_slot(lr, b, st);
      cap[5'(s)] = b;
      all_st &= st;
      if (!i2s) begin
        if (s < 24) exp[5'(s)] = w[5'(23 - s)];
      end else if (s == 0) begin
        exp[0] = (prev_len == 16) ? prev_w[8] : 1'b0;
      end else if (s <= 24) begin
        exp[5'(s)] = w[5'(24 - s)];
      end
    end
    check(cap == exp, tag, cap, exp);
    check(all_st, "R2 data steady during bit clock high", {31'd0, all_st}, 32'd1);
    prev_w = w;
    prev_len = n;
  endtask

  task automatic run_frame(input logic [23:0] l, input logic [23:0] r, input bit i2s, input int n, input string tag);
    left_in = l; right_in = r;
    run_half(i2s ? 1'b0 : 1'b1, l, n, i2s, {tag, " left"});
    left_in = ~l; right_in = ~r;   // R6: later input changes must not reach the right half
    run_half(i2s ? 1'b1 : 1'b0, r, n, i2s, {tag, " right"});
  endtask

  task automatic reenter(input bit i2s, input logic idle_lr);
    @(negedge clk); pwr_dn = 1'b1;
    fmt_i2s = i2s; lrck = idle_lr;
    repeat (3) @(negedge clk);
    pwr_dn = 1'b0;
    prev_w = '0; prev_len = 32;
  endtask

  task automatic test_reset;
    logic b, st, any;
    check(sdata == 1'b0, "R1 sdata low after reset", {31'd0, sdata}, 32'd0);
    left_in = 24'hFFFFFF; right_in = 24'hFFFFFF; any = 1'b0;
    for (int s = 0; s < 6; s++) begin
      drive_slot(1'b0, b, st);
      any |= b;
    end
    check(any == 1'b0, "R1 no output before first frame edge", {31'd0, any}, 32'd0);
  endtask

  task automatic test_lj_long;
    run_frame(24'h800001, 24'h7FFFFF, 1'b0, 32, "R3 R5 R6 LJ 64fs frame A");
    run_frame(24'hA5C3F0, 24'h123456, 1'b0, 32, "R3 R5 R6 LJ 64fs frame B");
    run_frame(24'hFFFFFF, 24'h000000, 1'b0, 32, "R3 R5 R6 LJ 64fs frame C");
  endtask

  task automatic test_power_down;
    logic b, st, any;
    left_in = 24'hFFFFFF; right_in = 24'hFFFFFF;
    drive_slot(1'b1, b, st);
    check(b == 1'b1, "R7 precondition MSB high", {31'd0, b}, 32'd1);
    @(negedge clk); pwr_dn = 1'b1;
    @(negedge clk);
    check(sdata == 1'b0, "R7 low one clock after power-down", {31'd0, sdata}, 32'd0);
    any = 1'b0;
    for (int s = 0; s < 12; s++) begin
      drive_slot(((s / 3) % 2) == 0, b, st);
      any |= b;
    end
    check(any == 1'b0, "R7 low while powered down", {31'd0, any}, 32'd0);
  endtask

  task automatic test_i2s_long;
    reenter(1'b1, 1'b1);
    run_frame(24'hC00003, 24'h3FFFFC, 1'b1, 32, "R4 R5 R6 I2S 64fs frame A");
    run_frame(24'h5A5A5A, 24'h800000, 1'b1, 32, "R4 R5 R6 I2S 64fs frame B");
  endtask

  task automatic test_i2s_short;
    run_frame(24'hABCDEF, 24'h135799, 1'b1, 16, "R8 I2S 32fs frame A");
    run_frame(24'hFEDCBA, 24'h0F0F0F, 1'b1, 16, "R8 I2S 32fs frame B");
    run_frame(24'h00FF00, 24'hFF00FF, 1'b1, 16, "R8 I2S 32fs frame C");
  endtask

  task automatic test_lj_short;
    reenter(1'b0, 1'b0);
    run_frame(24'h9ABCDE, 24'h654321, 1'b0, 16, "R8 LJ 32fs frame A");
    run_frame(24'h0000FF, 24'hFF0000, 1'b0, 16, "R8 LJ 32fs frame B");
    run_frame(24'h2468AC, 24'hDB9753, 1'b0, 32, "R3 R5 LJ back to 64fs");
  endtask

  initial begin
    rst_n = 1'b0; pwr_dn = 1'b0; fmt_i2s = 1'b0; bclk = 1'b1; lrck = 1'b0;
    left_in = '0; right_in = '0; prev_w = '0; prev_len = 32;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset;
    test_lj_long;
    test_power_down;
    test_i2s_long;
    test_i2s_short;
    test_lj_short;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule